// File: doc/BRIEF.md
# Overlapped Fetch-Execute Timing Sequencer

This block generates the cycle timing states for a small 8-bit accumulator machine and drives the datapath that goes with them. It runs four instructions: load X immediate, load A immediate, add-with-carry immediate and store A to zero page. Every other opcode is treated as a two-cycle no-operation. The machine never spends a cycle doing nothing between instructions. The closing work of one instruction happens in the same cycle as the opcode fetch of the next, so most instructions take two cycles and the store takes three.

The timing states are T1, T2, T0 and a merged T0+T2. T1 is the opcode fetch. In T1 the instruction register still holds the previous opcode, so T1 also finishes that previous instruction. A new instruction begins in the cycle after its opcode is read. An immediate instruction uses the merged state, which fetches the operand and does the end-of-instruction duties in the same cycle. The store uses T2 to fetch its zero-page address and T0 to write, with T1 following each.

The block talks to a synchronous byte-wide memory that has one cycle of read latency. It exposes A, X, carry, the current timing state and a sticky flag that records an interrupt request seen in a polling state.

Top module: `ofx_core`

## Requirements
- R1: While reset is held, the timing state reads T1, `mem_addr` equals the START_ADDR parameter, `mem_we` is 0 and A, X, carry and `irq_pending` are all 0. The timing state is encoded as T0=0, T1=1, T2=2 and T0+T2=3.
- R2: T1 is always followed by T2 or by T0+T2. A T2 cycle is taken only when the byte read back in that cycle is the store opcode 0x85, and it is followed by T0. T0 and T0+T2 are each followed by T1.
- R3: In T1, T2 and T0+T2 the block reads at the program counter. Each such read advances the counter by one, so every instruction occupies two consecutive bytes.
- R4: For load X (0xA2) and load A (0xA9), the operand byte is written into the target register at the end of the T1 that follows. The register keeps its old value during that T1.
- R5: For add-with-carry (0x69), A + operand + carry is computed in the following T1. Bit 8 of the sum goes into carry at the end of that T1. The low byte is written into A only at the end of the next cycle, which is the next instruction's T2 or T0+T2.
- R6: `mem_we` is 1 only in T0. In that cycle `mem_addr` is the zero-extended zero-page byte and `mem_wdata` is A, which already includes any add write-back that was still pending.
- R7: Any opcode other than the four above takes two cycles (T1, T0+T2), skips its operand byte and leaves A, X and carry unchanged.
- R8: `irq` is sampled only in T0 and in T0+T2. A high sample sets `irq_pending`, which stays set until reset. A high `irq` in T1 or T2 has no effect.
- R9: The program load X #1, load A #2, add #3, store 0x41 ends with X=1, A=5, carry 0 and the byte 5 at address 0x41.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | Interrupt request level |
| mem_rdata | input | 8 | Read data, one cycle after the address |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable |
| reg_a | output | 8 | Accumulator |
| reg_x | output | 8 | Index register X |
| flag_c | output | 1 | Carry flag |
| tstate | output | 2 | Timing state (T0=0, T1=1, T2=2, T0+T2=3) |
| irq_pending | output | 1 | Sticky record of an interrupt request seen while polling |

## Verification
The hardest case to reach is an add whose result is still waiting for write-back when the next instruction already needs A. This happens with an add directly followed by another add, or directly followed by a store that must write the new sum. The random programs mix all opcode kinds back to back, so these pairings come up many times. Directed programs pin the exact cycle in which A, X and carry change. The interrupt case needs `irq` raised in T1 alone and then in the merged state alone, which a directed sequence drives cycle by cycle.

// File: rtl/ofx_pkg.sv
package ofx_pkg;

    localparam int DW = 8;

    typedef enum logic [1:0] {
        TS_T0  = 2'd0,
        TS_T1  = 2'd1,
        TS_T2  = 2'd2,
        TS_T02 = 2'd3
    } tstate_e;

    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_DECODE = 2'd1,
        PH_FINISH = 2'd2
    } phase_e;

    typedef enum logic [2:0] {
        K_NONE = 3'd0,
        K_LDX  = 3'd1,
        K_LDA  = 3'd2,
        K_ADC  = 3'd3,
        K_STA  = 3'd4
    } kind_e;

    localparam logic [DW-1:0] OP_LDX_IMM = 8'hA2;
    localparam logic [DW-1:0] OP_LDA_IMM = 8'hA9;
    localparam logic [DW-1:0] OP_ADC_IMM = 8'h69;
    localparam logic [DW-1:0] OP_STA_ZP  = 8'h85;

    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] x;
        logic          c;
    } regs_t;

    typedef struct packed {
        logic          pend;
        logic [DW-1:0] val;
    } wback_t;

    function automatic kind_e classify(input logic [DW-1:0] op);
        kind_e k;
        case (op)
            OP_LDX_IMM: k = K_LDX;
            OP_LDA_IMM: k = K_LDA;
            OP_ADC_IMM: k = K_ADC;
            OP_STA_ZP:  k = K_STA;
            default:    k = K_NONE;
        endcase
        return k;
    endfunction

    function automatic logic needs_finish(input kind_e k);
        return (k == K_STA);
    endfunction

endpackage

// File: rtl/ofx_seq.sv
module ofx_seq
    import ofx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  kind_e   rd_kind,
    output phase_e  phase,
    output tstate_e ts,
    output logic    poll
);

    phase_e phase_nx;

    always_comb begin
        case (phase)
            PH_FETCH:  phase_nx = PH_DECODE;
            PH_DECODE: phase_nx = needs_finish(rd_kind) ? PH_FINISH : PH_FETCH;
            default:   phase_nx = PH_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_FETCH;
        else     phase <= phase_nx;
    end

    always_comb begin
        case (phase)
            PH_FETCH:  ts = TS_T1;
            PH_DECODE: ts = needs_finish(rd_kind) ? TS_T2 : TS_T02;
            default:   ts = TS_T0;
        endcase
    end

    assign poll = (ts == TS_T0) || (ts == TS_T02);

endmodule

// File: rtl/ofx_pc.sv
module ofx_pc #(
    parameter int            AW    = 16,
    parameter logic [AW-1:0] START = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    output logic [AW-1:0] pc
);

    always_ff @(posedge clk) begin
        if (rst)      pc <= START;
        else if (inc) pc <= pc + AW'(1);
    end

endmodule

// File: rtl/ofx_adder.sv
module ofx_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [W:0] carry;

    assign carry[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]     = a[i] ^ b[i] ^ carry[i];
        assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
    end

    assign cout = carry[W];

endmodule

// File: rtl/ofx_core.sv
module ofx_core
    import ofx_pkg::*;
#(
    parameter int            AW         = 16,
    parameter logic [AW-1:0] START_ADDR = 16'h0010
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          irq,
    input  logic [7:0]    mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          mem_we,
    output logic [7:0]    reg_a,
    output logic [7:0]    reg_x,
    output logic          flag_c,
    output logic [1:0]    tstate,
    output logic          irq_pending
);

    localparam int ZPAD = AW - DW;

    kind_e         rd_kind;
    kind_e         ir_kind;
    phase_e        phase;
    tstate_e       ts;
    logic          poll;
    logic          pc_inc;
    logic [AW-1:0] pc;
    logic          retire_ok;
    regs_t         rf;
    wback_t        wb;
    logic [DW-1:0] add_sum;
    logic          add_cout;

    assign rd_kind = classify(mem_rdata);

    ofx_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .rd_kind (rd_kind),
        .phase   (phase),
        .ts      (ts),
        .poll    (poll)
    );

    assign pc_inc = (phase == PH_FETCH) || (phase == PH_DECODE);

    ofx_pc #(.AW(AW), .START(START_ADDR)) u_pc (
        .clk (clk),
        .rst (rst),
        .inc (pc_inc),
        .pc  (pc)
    );

    ofx_adder #(.W(DW)) u_add (
        .a    (rf.a),
        .b    (mem_rdata),
        .cin  (rf.c),
        .sum  (add_sum),
        .cout (add_cout)
    );

    // Finish phase: the zero-page byte arrives on read data and is the write address.
    assign mem_addr  = (phase == PH_FINISH) ? {{ZPAD{1'b0}}, mem_rdata} : pc;
    assign mem_we    = (phase == PH_FINISH);
    assign mem_wdata = rf.a;

    always_ff @(posedge clk) begin
        if (rst) begin
            rf          <= '0;
            wb          <= '0;
            ir_kind     <= K_NONE;
            retire_ok   <= 1'b0;
            irq_pending <= 1'b0;
        end else begin
            case (phase)
                PH_FETCH: begin
                    // Operand of the previous instruction is on read data now.
                    if (retire_ok) begin
                        case (ir_kind)
                            K_LDX: rf.x <= mem_rdata;
                            K_LDA: rf.a <= mem_rdata;
                            K_ADC: begin
                                rf.c    <= add_cout;
                                wb.val  <= add_sum;
                                wb.pend <= 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
                PH_DECODE: begin
                    ir_kind   <= rd_kind;
                    retire_ok <= 1'b1;
                    if (wb.pend) rf.a <= wb.val;
                    wb.pend   <= 1'b0;
                end
                default: ;
            endcase
            if (poll && irq) irq_pending <= 1'b1;
        end
    end

    assign reg_a  = rf.a;
    assign reg_x  = rf.x;
    assign flag_c = rf.c;
    assign tstate = ts;

endmodule

// File: rtl/ofx_core_chk.sv
module ofx_core_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          irq,
    input logic [AW-1:0] mem_addr,
    input logic          mem_we,
    input logic [7:0]    reg_a,
    input logic [7:0]    reg_x,
    input logic          flag_c,
    input logic [1:0]    tstate,
    input logic          irq_pending
);

    p_t1_next_r2: assert property (@(posedge clk) disable iff (rst)
        tstate == 2'd1 |=> (tstate == 2'd2 || tstate == 2'd3));

    p_t2_to_t0_r2: assert property (@(posedge clk) disable iff (rst)
        tstate == 2'd2 |=> tstate == 2'd0);

    p_end_to_t1_r2: assert property (@(posedge clk) disable iff (rst)
        (tstate == 2'd0 || tstate == 2'd3) |=> tstate == 2'd1);

    p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
        (tstate == 2'd2 || tstate == 2'd3) |-> mem_addr == $past(mem_addr) + {{(AW-1){1'b0}}, 1'b1});

    p_x_after_t1_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(reg_x) |-> $past(tstate) == 2'd1);

    p_carry_after_t1_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(flag_c) |-> $past(tstate) == 2'd1);

    p_a_change_window_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(reg_a) |-> ($past(tstate) == 2'd1 || $past(tstate) == 2'd2 || $past(tstate) == 2'd3));

    p_we_only_t0_r6: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> tstate == 2'd0);

    p_irq_poll_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_pending) |-> ($past(irq) && ($past(tstate) == 2'd0 || $past(tstate) == 2'd3)));

    p_irq_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        irq_pending |=> irq_pending);

endmodule

bind ofx_core ofx_core_chk #(.AW(AW)) u_chk (.*);

// File: tb/ofx_core_test.sv
module ofx_core_test;

    localparam int           AW    = 16;
    localparam logic [15:0]  START = 16'h0010;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq = 1'b0;
    logic [7:0]  mem_rdata = 8'h00;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  reg_a, reg_x;
    logic        flag_c;
    logic [1:0]  tstate;
    logic        irq_pending;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] mem [0:255];
    logic [7:0] p_op  [0:63];
    logic [7:0] p_arg [0:63];
    int         nprog;
    logic [7:0] ra, rx;
    logic       rc;
    logic [7:0] rmem [0:255];

    always #10 clk = ~clk;

    ofx_core #(.AW(AW), .START_ADDR(START)) uut (
        .clk(clk), .rst(rst), .irq(irq), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .reg_a(reg_a), .reg_x(reg_x), .flag_c(flag_c),
        .tstate(tstate), .irq_pending(irq_pending)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[7:0]];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic load_prog();
        for (int i = 0; i < 256; i++) begin
            mem[i]  = 8'hEA;
            rmem[i] = 8'hEA;
        end
        for (int i = 0; i < nprog; i++) begin
            mem[START[7:0] + 2*i]     = p_op[i];
            mem[START[7:0] + 2*i + 1] = p_arg[i];
        end
        ra = 0; rx = 0; rc = 0;
    endtask

    task automatic start();
        rst = 1'b1;
        irq = 1'b0;
        repeat (3) step();
        check(tstate == 2'd1, "R1", "reset tstate", tstate, 1);
        check(mem_addr == START, "R1", "reset addr", mem_addr, START);
        check(mem_we == 1'b0, "R1", "reset we", mem_we, 0);
        check({reg_a, reg_x, flag_c, irq_pending} == '0, "R1", "reset regs",
              {reg_a, reg_x, flag_c, irq_pending}, 0);
        rst = 1'b0;
    endtask

    task automatic ref_exec(input logic [7:0] op, input logic [7:0] arg);
        logic [8:0] s;
        case (op)
            8'hA2: rx = arg;
            8'hA9: ra = arg;
            8'h69: begin s = {1'b0, ra} + {1'b0, arg} + {8'd0, rc}; ra = s[7:0]; rc = s[8]; end
            8'h85: rmem[arg] = ra;
            default: ;
        endcase
    endtask

    task automatic run_trace();
        for (int i = 0; i < nprog; i++) begin
            check(tstate == 2'd1, "R2", "T1 expected", tstate, 1);
            check(mem_addr == START + 16'(2*i), "R3", "fetch address", mem_addr, START + 16'(2*i));
            check(mem_we == 1'b0, "R6", "we outside T0", mem_we, 0);
            step();
            if (p_op[i] == 8'h85) begin
                check(tstate == 2'd2, "R2", "T2 for store", tstate, 2);
                step();
                check(tstate == 2'd0, "R2", "T0 for store", tstate, 0);
                check(mem_we == 1'b1, "R6", "we in T0", mem_we, 1);
                check(mem_addr == {8'h00, p_arg[i]}, "R6", "store addr", mem_addr, {8'h00, p_arg[i]});
                check(mem_wdata == ra, "R6", "store data", mem_wdata, ra);
                step();
            end else begin
                check(tstate == 2'd3, (p_op[i] == 8'hA2 || p_op[i] == 8'hA9 || p_op[i] == 8'h69) ? "R2" : "R7",
                      "merged state", tstate, 3);
                step();
            end
            ref_exec(p_op[i], p_arg[i]);
        end
        repeat (3) step();
        check(reg_a == ra, "R9", "final A", reg_a, ra);
        check(reg_x == rx, "R4", "final X", reg_x, rx);
        check(flag_c == rc, "R5", "final carry", flag_c, rc);
    endtask

    initial begin
        void'($urandom(32'd4242));

        // R9 example program
        nprog = 4;
        p_op[0] = 8'hA2; p_arg[0] = 8'h01;
        p_op[1] = 8'hA9; p_arg[1] = 8'h02;
        p_op[2] = 8'h69; p_arg[2] = 8'h03;
        p_op[3] = 8'h85; p_arg[3] = 8'h41;
        load_prog();
        start();
        run_trace();
        check(reg_x == 8'd1 && reg_a == 8'd5, "R9", "X/A after program", {reg_x, reg_a}, 16'h0105);
        check(mem[8'h41] == 8'd5, "R9", "memory 0x41", mem[8'h41], 5);

        // R4 exact write cycle for load X
        nprog = 1;
        p_op[0] = 8'hA2; p_arg[0] = 8'h07;
        load_prog();
        start();
        step(); step();
        check(reg_x == 8'h00, "R4", "X unchanged during T1", reg_x, 0);
        step();
        check(reg_x == 8'h07, "R4", "X after T1", reg_x, 7);

        // R5 add timing: carry after T1, A only after next T2
        nprog = 2;
        p_op[0] = 8'hA9; p_arg[0] = 8'hF0;
        p_op[1] = 8'h69; p_arg[1] = 8'h20;
        load_prog();
        start();
        repeat (5) step();
        check(flag_c == 1'b1, "R5", "carry after T1", flag_c, 1);
        check(reg_a == 8'hF0, "R5", "A held before write-back", reg_a, 8'hF0);
        step();
        check(reg_a == 8'h10, "R5", "A after write-back", reg_a, 8'h10);

        // R8 interrupt sampling
        nprog = 0;
        load_prog();
        start();
        irq = 1'b1;
        step();
        irq = 1'b0;
        check(irq_pending == 1'b0, "R8", "irq in T1 ignored", irq_pending, 0);
        step();
        check(irq_pending == 1'b0, "R8", "still clear", irq_pending, 0);
        step();
        irq = 1'b1;
        step();
        irq = 1'b0;
        check(irq_pending == 1'b1, "R8", "irq in merged state", irq_pending, 1);
        repeat (4) step();
        check(irq_pending == 1'b1, "R8", "pending sticky", irq_pending, 1);

        // random programs
        for (int t = 0; t < 12; t++) begin
            nprog = 24;
            for (int i = 0; i < nprog; i++) begin
                int k;
                k = int'($urandom_range(0, 5));
                p_arg[i] = 8'($urandom);
                case (k)
                    0: p_op[i] = 8'hA2;
                    1: p_op[i] = 8'hA9;
                    2: p_op[i] = 8'h69;
                    3: begin p_op[i] = 8'h85; p_arg[i] = 8'($urandom_range(8'hC0, 8'hFF)); end
                    4: p_op[i] = 8'hEA;
                    default: begin
                        p_op[i] = 8'($urandom);
                        if (p_op[i] == 8'hA2 || p_op[i] == 8'hA9 || p_op[i] == 8'h69 || p_op[i] == 8'h85)
                            p_op[i] = 8'h00;
                    end
                endcase
            end
            load_prog();
            start();
            run_trace();
            for (int z = 8'hC0; z < 256; z++)
                check(mem[z] == rmem[z], "R6", "zero-page byte", mem[z], rmem[z]);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule